// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a 7-bit digital step attenuator and loads a new attenuation setting into it over a three-wire serial link: a serial clock, a data line and a latch strobe. A requester presents a 7-bit attenuation code together with a one-cycle start strobe. The block then shifts the code out, most significant bit first, and follows the last bit with a latch pulse that transfers the word into the attenuator. Bit 6 of the code selects the largest (16 dB) stage and bit 0 the smallest (0.25 dB) stage. The attenuation applied is the sum of the selected stages.

Every interface timing limit is a parameter in nanoseconds, together with the system clock period. Each limit is converted to a whole number of system cycles, rounded up, at elaboration. With the defaults (4 ns clock, 70 ns minimum serial period, 15 ns setup, 20 ns hold, 15 ns latch setup, 10 ns latch width, 630 ns latch spacing) the derived counts are as follows:

- serial clock low phase: 9 cycles
- serial clock high phase: 9 cycles
- latch setup: 4 cycles
- latch pulse: 3 cycles
- enforced gap: 158 cycles

The latch strobe stays low for the whole of the shift, because the attenuator ignores clock edges while its latch input is high. After the latch pulse the block stays busy for the full spacing interval, and any start that arrives while it is busy is dropped.

Top module: `attn_ser_master`

## Requirements
- R1: Each accepted request sends exactly 7 rising serial clock edges before the latch pulse. The bits go out most significant first, so the word captured at the rising edges equals code_i as it was sampled with start_i.
- R2: Each serial clock cycle is low for LO cycles and then high for HI cycles. LO is the larger of the rounded-up setup time and the rounded-up half of the minimum serial period. HI is the larger of the rounded-up hold time and that same half period. The defaults give LO = 9 and HI = 9.
- R3: The data line changes only while the serial clock is low. It is valid for the whole low phase before each rising edge and holds through the whole high phase after it.
- R4: The latch strobe is low at every serial clock edge. It rises exactly LES cycles (4 by default) after the serial clock falls for the last time.
- R5: The latch strobe stays high for exactly LEW cycles (3 by default).
- R6: After the latch strobe falls, busy_o stays high for exactly GAP cycles (158 by default) before it drops. Consecutive latch rising edges are therefore at least GAP cycles apart.
- R7: done_o is high for exactly one cycle, the cycle in which the latch strobe has just fallen.
- R8: A start_i seen while busy_o is high has no effect. Neither the outputs nor the next latched word change.
- R9: After reset, and whenever the block is idle, sck_o, sdat_o, le_o, busy_o and done_o are all low.
- R10: A start_i sampled while idle is taken at that clock edge. busy_o and the first data bit appear right after that edge, and the first low phase begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| code_i | input | 7 | Attenuation code; bit 6 is the 16 dB stage |
| sck_o | output | 1 | Serial clock to the attenuator |
| sdat_o | output | 1 | Serial data to the attenuator |
| le_o | output | 1 | Latch strobe to the attenuator |
| busy_o | output | 1 | High from acceptance to the end of the spacing gap |
| done_o | output | 1 | One-cycle pulse when the latch pulse ends |

## Verification
All outputs are registered, so the effect of a start sampled at one clock edge shows immediately after that edge. From there the rest of the transaction follows a fixed schedule:

- the shift takes 7 × (LO + HI) cycles;
- then LES cycles of latch setup;
- then LEW cycles with the latch strobe high;
- then GAP busy cycles, with done_o marking the first of them.

The bench model expands each accepted request into this per-cycle expectation queue and compares every output at the falling clock edge, half a cycle after the registers update. A second, independent receiver model captures the data at each rising serial clock edge. It checks the latched word and the spacing between latch edges, which also shows that starts dropped during busy left no trace.

// File: rtl/attn_ser_pkg.sv
package attn_ser_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOW    = 3'd1,
        PH_HIGH   = 3'd2,
        PH_LSETUP = 3'd3,
        PH_LPULSE = 3'd4,
        PH_GAP    = 3'd5
    } phase_e;

    typedef struct packed {
        logic sck;
        logic sdat;
        logic le;
    } link_pins_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/attn_ser_cnt.sv
module attn_ser_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == limit);
endmodule

// File: rtl/attn_ser_shreg.sv
module attn_ser_shreg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         following,
    output logic         last_bit
);
    localparam int RW = $clog2(W + 1);

    logic [W-1:0]  sr_q;
    logic [RW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= '0;
            remain_q <= '0;
        end else if (load) begin
            sr_q     <= word;
            remain_q <= RW'(W);
        end else if (shift) begin
            sr_q     <= {sr_q[W-2:0], 1'b0};
            remain_q <= remain_q - 1'b1;
        end
    end

    assign following = sr_q[W-2];
    assign last_bit  = (remain_q == RW'(1));

    AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        shift |-> (remain_q > RW'(1)))
        else $error("shift past last bit"); // R1
endmodule

// File: rtl/attn_ser_master.sv
module attn_ser_master
    import attn_ser_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int CLK_NS      = 4,
    parameter int SCK_MIN_NS  = 70,
    parameter int SETUP_NS    = 15,
    parameter int HOLD_NS     = 20,
    parameter int LE_SETUP_NS = 15,
    parameter int LE_WIDTH_NS = 10,
    parameter int LE_GAP_NS   = 630
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              sck_o,
    output logic              sdat_o,
    output logic              le_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int HALF_C = ns_to_cyc((SCK_MIN_NS + 1) / 2, CLK_NS);
    localparam int LO_C   = max2(ns_to_cyc(SETUP_NS, CLK_NS), HALF_C);
    localparam int HI_C   = max2(ns_to_cyc(HOLD_NS, CLK_NS), HALF_C);
    localparam int LES_C  = ns_to_cyc(LE_SETUP_NS, CLK_NS);
    localparam int LEW_C  = ns_to_cyc(LE_WIDTH_NS, CLK_NS);
    localparam int GAP_C  = ns_to_cyc(LE_GAP_NS, CLK_NS);
    localparam int MAX_C  = max2(max2(max2(LO_C, HI_C), max2(LES_C, LEW_C)), GAP_C);
    localparam int CW     = $clog2(MAX_C + 1);
    localparam int GW     = $clog2(GAP_C + 1);

    phase_e        phase_q;
    link_pins_t    pins_q;
    logic          busy_q;
    logic          done_q;
    logic          ph_last;
    logic          cnt_clr;
    logic [CW-1:0] ph_limit;
    logic          sh_load;
    logic          sh_shift;
    logic          sh_follow;
    logic          sh_last;

    // Phase length selection
    always_comb begin
        case (phase_q)
            PH_LOW:    ph_limit = CW'(LO_C - 1);
            PH_HIGH:   ph_limit = CW'(HI_C - 1);
            PH_LSETUP: ph_limit = CW'(LES_C - 1);
            PH_LPULSE: ph_limit = CW'(LEW_C - 1);
            PH_GAP:    ph_limit = CW'(GAP_C - 1);
            default:   ph_limit = '0;
        endcase
    end

    assign cnt_clr  = (phase_q == PH_IDLE) || ph_last;
    assign sh_load  = (phase_q == PH_IDLE) && start_i;
    assign sh_shift = (phase_q == PH_HIGH) && ph_last && !sh_last;

    attn_ser_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .limit (ph_limit),
        .last  (ph_last)
    );

    attn_ser_shreg #(.W(CODE_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .word      (code_i),
        .shift     (sh_shift),
        .following (sh_follow),
        .last_bit  (sh_last)
    );

    // Sequencer: all link pins come straight from flops
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pins_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q     <= PH_LOW;
                        pins_q.sdat <= code_i[CODE_W-1];
                        busy_q      <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (ph_last) begin
                        phase_q    <= PH_HIGH;
                        pins_q.sck <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (ph_last) begin
                        pins_q.sck <= 1'b0;
                        if (sh_last) begin
                            phase_q     <= PH_LSETUP;
                            pins_q.sdat <= 1'b0;
                        end else begin
                            phase_q     <= PH_LOW;
                            pins_q.sdat <= sh_follow;
                        end
                    end
                end
                PH_LSETUP: begin
                    if (ph_last) begin
                        phase_q   <= PH_LPULSE;
                        pins_q.le <= 1'b1;
                    end
                end
                PH_LPULSE: begin
                    if (ph_last) begin
                        phase_q   <= PH_GAP;
                        pins_q.le <= 1'b0;
                        done_q    <= 1'b1;
                    end
                end
                PH_GAP: begin
                    if (ph_last) begin
                        phase_q <= PH_IDLE;
                        busy_q  <= 1'b0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign sck_o  = pins_q.sck;
    assign sdat_o = pins_q.sdat;
    assign le_o   = pins_q.le;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Cycles the latch strobe has been low, saturating at the gap length
    logic [GW-1:0] le_low_q;
    always_ff @(posedge clk) begin
        if (rst)                      le_low_q <= GW'(GAP_C);
        else if (le_o)                le_low_q <= '0;
        else if (le_low_q != GW'(GAP_C)) le_low_q <= le_low_q + 1'b1;
    end

    AST_LE_SPACING: assert property (@(posedge clk) disable iff (rst)
        $rose(le_o) |-> (le_low_q == GW'(GAP_C)))
        else $error("latch pulses too close"); // R6
    AST_LE_LOW_AT_SCK: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !le_o)
        else $error("latch high while clocking"); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sck_o && $past(sck_o)) |-> $stable(sdat_o))
        else $error("data moved in high phase"); // R3
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) |-> $stable(sdat_o))
        else $error("data moved at rising edge"); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done longer than one cycle"); // R7
    AST_DONE_AT_LE_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(le_o) |-> done_o)
        else $error("no done at latch end"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sck_o && !sdat_o && !le_o && !done_o))
        else $error("idle pins not low"); // R9
endmodule

// File: tb/attn_ser_master_tb_top.sv
module attn_ser_master_tb_top;
    localparam int LO  = 9;
    localparam int HI  = 9;
    localparam int LES = 4;
    localparam int LEW = 3;
    localparam int GAP = 158;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [6:0] code_i = '0;
    logic       sck_o, sdat_o, le_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    attn_ser_master dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .code_i(code_i),
        .sck_o(sck_o), .sdat_o(sdat_o), .le_o(le_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at t=%0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Reference model: per-cycle {busy,done,sck,sdat,le}
    logic [4:0] exp_q[$];
    logic [6:0] word_q[$];
    bit         idle_shown = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            word_q.delete();
        end else if (idle_shown && start_i) begin
            // R10: request taken at this edge
            word_q.push_back(code_i);
            for (int b = 6; b >= 0; b--) begin
                for (int i = 0; i < LO; i++) exp_q.push_back({1'b1, 1'b0, 1'b0, code_i[b], 1'b0});
                for (int i = 0; i < HI; i++) exp_q.push_back({1'b1, 1'b0, 1'b1, code_i[b], 1'b0});
            end
            for (int i = 0; i < LES; i++) exp_q.push_back(5'b10000);
            for (int i = 0; i < LEW; i++) exp_q.push_back(5'b10001);
            exp_q.push_back(5'b11000);
            for (int i = 1; i < GAP; i++) exp_q.push_back(5'b10000);
        end
    end

    // Receiver model
    logic [6:0] rx_sr = '0;
    int         rx_cnt = 0;
    logic       sck_prev = 1'b0;
    logic       le_prev = 1'b0;
    int         since_le = 100000;

    always @(negedge clk) begin
        logic [4:0] e;
        cycles++;
        if (!rst) begin
            if (exp_q.size() == 0) begin
                e = 5'b00000;
                idle_shown = 1'b1;
            end else begin
                e = exp_q.pop_front();
                idle_shown = 1'b0;
            end
            chk("R6/R8 busy_o", busy_o, e[4]);
            chk("R7 done_o", done_o, e[3]);
            chk("R2 sck_o", sck_o, e[2]);
            chk("R3 sdat_o", sdat_o, e[1]);
            chk("R4/R5 le_o", le_o, e[0]);
            if (sck_o && !sck_prev) begin
                chk("R4 le low at sck rise", le_o, 0);
                rx_sr = {rx_sr[5:0], sdat_o};
                rx_cnt++;
            end
            since_le++;
            if (le_o && !le_prev) begin
                logic [6:0] w;
                w = (word_q.size() != 0) ? word_q.pop_front() : 7'h7f;
                chk("R1 latched word", rx_sr, w);
                chk("R1 bit count", rx_cnt, 7);
                chk("R6 latch spacing ok", (since_le >= GAP) ? 1 : 0, 1);
                rx_cnt = 0;
                since_le = 0;
            end
        end else begin
            idle_shown = 1'b1;
        end
        sck_prev = sck_o;
        le_prev = le_o;
    end

    task automatic send(input logic [6:0] c);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        #1;
        start_i = 1'b1;
        code_i  = c;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        code_i  = 7'h00;
    endtask

    task automatic poke_busy(input logic [6:0] c, input int wait_cyc);
        for (int i = 0; i < wait_cyc; i++) @(negedge clk);
        #1;
        start_i = 1'b1;
        code_i  = c;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        code_i  = 7'h00;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        while (cycles < 150000) @(negedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 reset sck", sck_o, 0);
        chk("R9 reset sdat", sdat_o, 0);
        chk("R9 reset le", le_o, 0);
        chk("R9 reset busy", busy_o, 0);
        chk("R9 reset done", done_o, 0);
        #1 rst = 1'b0;
        repeat (5) @(negedge clk);

        send(7'h55);
        poke_busy(7'h7f, 20);   // R8: during shift
        poke_busy(7'h7f, 140);  // R8: during gap
        drain();
        send(7'h00);
        drain();
        send(7'h7f);
        drain();
        send(7'h2a);
        poke_busy(7'h11, 126);  // R8: near latch
        drain();
        send(7'h40);
        drain();
        send(7'h01);
        drain();

        // R10: start held high, taken again as soon as idle
        @(negedge clk);
        #1;
        start_i = 1'b1;
        code_i  = 7'h33;
        repeat (700) @(negedge clk);
        #1;
        start_i = 1'b0;
        drain();
        chk("R9 idle after run", {sck_o, sdat_o, le_o, busy_o, done_o}, 0);
        chk("R1 all words latched", word_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule